// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer. Software reaches it through a small bus of 16-bit registers. A prescaler divides the input clock into a half-second tick. Software programs a timeout in half-second steps and then starts the watchdog. From that point the watchdog cannot be stopped. To keep the countdown from reaching zero, software must write two key words to the service register, in a fixed order.

When the countdown reaches zero, the block pulses a reset request for one clock. If software has selected it, the block also pulls an active-low external reset pin low and holds it there until a system reset. A backstop interrupt can be armed with a pre-timeout count. With that count at zero, the interrupt rises on the same edge as the external reset. Separately, a power-down watchdog runs from reset with a fixed length. It also requests a reset when it runs out, until software switches it off for good.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, CTRL (word 0) reads 0x0000, INTCTL (word 2) reads 0x0000, MISC (word 3) reads 0x0001 (power-down watchdog on), ext_rst_n is 1 and both rst_req and irq are 0.
- R2: CTRL bit 0 (run) starts the watchdog. Once it is 1, a write of 0 to it leaves it reading 1.
- R3: CTRL bits 15:8 (timeout code F, timeout = (F+1) half-second ticks, so F = 2T-1 for T seconds) and CTRL bit 1 (external-reset select) take the value of the write that sets run. Any later write to them is ignored, as seen on readback.
- R4: With run set and no servicing, rst_req goes high on the (F+1)th tick after the write that set run, and not before.
- R5: Writing 0x5555 and then 0x AAAA to SVC (word 1), with no other SVC write between them, reloads the countdown. Servicing more often than the timeout keeps rst_req low.
- R6: An SVC write sequence that does not follow that order (second key alone, or the first key followed by any other word) does not reload the countdown.
- R7: Each expiry drives rst_req high for exactly one clock.
- R8: When external-reset select is 1, ext_rst_n goes low on the expiry edge and stays low until rst_n. When it is 0, ext_rst_n stays high.
- R9: INTCTL bit 14 (status) is set by the pre-timeout event. irq = status AND INTCTL bit 15 (enable). With INTCTL bits 7:0 (pre count P) equal to 0, status sets on the expiry edge. Writing 1 to bit 14 clears it.
- R10: With P nonzero, status sets on the tick at which the countdown reaches P, exactly P ticks before rst_req.
- R11: The power-down watchdog (MISC bit 0) pulses rst_req PD_TICKS ticks after reset. Writing 0 to the bit stops it for good: a later write of 1 reads back 0 and no request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| rst_req | output | 1 | One-clock reset request on expiry |
| ext_rst_n | output | 1 | Active-low external reset, latched on expiry |
| irq | output | 1 | Backstop interrupt |

## Verification
A countdown that loads wrongly, or misses a reload, moves the rst_req pulse outside a window one tick wide. That shows up within a single timeout of the enabling or servicing write. A key matcher that gets stuck shows either as an early rst_req during periodic servicing or as a late one after a malformed sequence. Errors in the configuration lock, the status clear or the power-down disable show up at once on register readback. Errors in the interrupt timing show as a gap between the rise of irq and rst_req that is not exactly P ticks.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_SVC  = 2'd1,
        A_ICTL = 2'd2,
        A_MISC = 2'd3
    } reg_addr_e;

    localparam logic [REG_W-1:0] KEY_FIRST  = 16'h5555;
    localparam logic [REG_W-1:0] KEY_SECOND = 16'hAAAA;

    // bit positions software relies on
    localparam int B_RUN     = 0;
    localparam int B_EXTSEL  = 1;
    localparam int B_TMO_LO  = 8;
    localparam int B_IE      = 15;
    localparam int B_ISTAT   = 14;
    localparam int B_PDE     = 0;

    typedef enum logic {
        SV_IDLE  = 1'b0,
        SV_ARMED = 1'b1
    } svc_state_e;

endpackage

// File: rtl/kwdt_tick_gen.sv
module kwdt_tick_gen #(
    parameter int DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tg_state_t;

    tg_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (s_q.cnt == LAST) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;

    generate
        if (DIV > 1) begin : g_pulse_chk
            AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
                s_q.tick |=> !s_q.tick); // R4
        end
    endgenerate

endmodule

// File: rtl/kwdt_key_seq.sv
module kwdt_key_seq
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_wr,
    input  logic [REG_W-1:0] wdata,
    output logic             svc_ok
);
    typedef struct packed {
        svc_state_e st;
        logic       ok;
    } ks_state_t;

    ks_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ok = 1'b0;
        if (svc_wr) begin
            if (wdata == KEY_FIRST) begin
                s_d.st = SV_ARMED;
            end else if (wdata == KEY_SECOND && s_q.st == SV_ARMED) begin
                s_d.st = SV_IDLE;
                s_d.ok = 1'b1;
            end else begin
                s_d.st = SV_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SV_IDLE, ok: 1'b0};
        else        s_q <= s_d;
    end

    assign svc_ok = s_q.ok;

    AST_KEY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ok |-> ($past(s_q.st) == SV_ARMED && $past(svc_wr)
                    && $past(wdata) == KEY_SECOND)); // R6

endmodule

// File: rtl/kwdt_down_ctr.sv
module kwdt_down_ctr #(
    parameter int CW      = 9,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          expire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } dc_state_t;

    dc_state_t s_d, s_q;
    logic      hit_zero;

    always_comb begin
        s_d      = s_q;
        hit_zero = 1'b0;
        if (load) begin
            s_d.cnt = load_val;
        end else if (run && tick) begin
            if (s_q.cnt <= CW'(1)) begin
                hit_zero = 1'b1;
                s_d.cnt  = load_val;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.cnt <= CW'(RST_VAL);
        else        s_q     <= s_d;
    end

    assign count  = s_q.cnt;
    assign expire = hit_zero;

    AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire); // R7

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int TICK_DIV = 50_000_000,
    parameter int TMO_W    = 8,
    parameter int PRE_W    = 8,
    parameter int PD_TICKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              rst_req,
    output logic              ext_rst_n,
    output logic              irq
);
    localparam int MC_W = TMO_W + 1;
    localparam int PD_W = $clog2(PD_TICKS + 1);

    typedef struct packed {
        logic             run;
        logic             ext_sel;
        logic [TMO_W-1:0] tmo;
        logic             ie;
        logic             istat;
        logic [PRE_W-1:0] pre;
        logic             pde;
        logic             ext_low;
        logic             req;
    } wdt_state_t;

    wdt_state_t s_d, s_q;

    logic            tick;
    logic            svc_ok;
    logic            main_load;
    logic            main_exp;
    logic [MC_W-1:0] main_cnt;
    logic [MC_W-1:0] main_reload;
    logic            pd_exp;
    logic [PD_W-1:0] pd_cnt;
    logic            pre_hit;
    logic            wr_ctrl, wr_svc, wr_ictl, wr_misc;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
    assign wr_svc  = bus_sel && bus_wr && (bus_addr == A_SVC);
    assign wr_ictl = bus_sel && bus_wr && (bus_addr == A_ICTL);
    assign wr_misc = bus_sel && bus_wr && (bus_addr == A_MISC);

    kwdt_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    kwdt_key_seq u_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .svc_wr (wr_svc),
        .wdata  (bus_wdata),
        .svc_ok (svc_ok)
    );

    assign main_reload = MC_W'(s_q.tmo) + MC_W'(1);
    // reload on the enabling write and on every valid key pair
    assign main_load   = svc_ok || (wr_ctrl && !s_q.run && bus_wdata[B_RUN]);

    kwdt_down_ctr #(.CW(MC_W), .RST_VAL(1)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (s_q.run),
        .load     (main_load),
        .load_val (wr_ctrl && !s_q.run ? MC_W'(bus_wdata[B_TMO_LO +: TMO_W]) + MC_W'(1)
                                        : main_reload),
        .count    (main_cnt),
        .expire   (main_exp)
    );

    kwdt_down_ctr #(.CW(PD_W), .RST_VAL(PD_TICKS)) u_pd (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (s_q.pde),
        .load     (1'b0),
        .load_val (PD_W'(PD_TICKS)),
        .count    (pd_cnt),
        .expire   (pd_exp)
    );

    assign pre_hit = s_q.run && tick && !main_load && (s_q.pre != '0)
                     && (main_cnt == MC_W'(s_q.pre) + MC_W'(1));

    always_comb begin
        s_d     = s_q;
        s_d.req = main_exp || pd_exp;

        if (wr_ctrl) begin
            if (!s_q.run) begin
                s_d.tmo     = bus_wdata[B_TMO_LO +: TMO_W];
                s_d.ext_sel = bus_wdata[B_EXTSEL];
                s_d.run     = bus_wdata[B_RUN];
            end
        end

        if (wr_ictl) begin
            s_d.ie  = bus_wdata[B_IE];
            s_d.pre = bus_wdata[PRE_W-1:0];
            if (bus_wdata[B_ISTAT]) s_d.istat = 1'b0;
        end

        if (wr_misc && !bus_wdata[B_PDE]) s_d.pde = 1'b0;

        if (main_exp) begin
            if (s_q.ext_sel) s_d.ext_low = 1'b1;
            if (s_q.pre == '0) s_d.istat = 1'b1;
        end
        if (pre_hit) s_d.istat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.pde <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                A_CTRL: begin
                    bus_rdata[B_TMO_LO +: TMO_W] = s_q.tmo;
                    bus_rdata[B_EXTSEL]          = s_q.ext_sel;
                    bus_rdata[B_RUN]             = s_q.run;
                end
                A_ICTL: begin
                    bus_rdata[B_IE]        = s_q.ie;
                    bus_rdata[B_ISTAT]     = s_q.istat;
                    bus_rdata[PRE_W-1:0]   = s_q.pre;
                end
                A_MISC:  bus_rdata[B_PDE] = s_q.pde;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign rst_req   = s_q.req;
    assign ext_rst_n = !s_q.ext_low;
    assign irq       = s_q.istat && s_q.ie;

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |=> s_q.run); // R2
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |=> ($stable(s_q.tmo) && $stable(s_q.ext_sel))); // R3
    AST_EXT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rst_n |=> !ext_rst_n); // R8
    AST_EXT_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_rst_n) |-> (s_q.ext_sel && rst_req)); // R8
    AST_IRQ_WITH_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ext_rst_n) && s_q.ie && s_q.pre == '0) |-> irq); // R9
    AST_PD_ONEWAY: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.pde |=> !s_q.pde); // R11

endmodule

// File: tb/tb_keyed_wdt.sv
`timescale 1ns/1ps
module tb_keyed_wdt;
    localparam int DIV = 8;
    localparam int PD  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_req, ext_rst_n, irq;

    int errors = 0, checks = 0;
    int cyc = 0;
    int req_cnt = 0;

    keyed_wdt #(.TICK_DIV(DIV), .PD_TICKS(PD)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .ext_rst_n(ext_rst_n), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_req) req_cnt <= req_cnt + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic do_reset(input bit kill_pd);
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        if (kill_pd) wr(2'd3, 16'h0000);
    endtask

    task automatic wait_req(input int max, output int at);
        at = -1;
        for (int i = 0; i < max && at < 0; i++) begin
            @(negedge clk);
            if (rst_req) at = cyc;
        end
    endtask

    task automatic t_reset_state();
        logic [15:0] d;
        do_reset(0);
        rd(2'd0, d); check(d == 16'h0000, "R1 ctrl", d, 0);
        rd(2'd2, d); check(d == 16'h0000, "R1 intctl", d, 0);
        rd(2'd3, d); check(d == 16'h0001, "R1 misc", d, 1);
        check(ext_rst_n && !rst_req && !irq, "R1 outputs",
              {ext_rst_n, rst_req, irq}, 3'b100);
    endtask

    task automatic t_lock();
        logic [15:0] d;
        do_reset(1);
        wr(2'd0, 16'h0303);
        rd(2'd0, d); check(d == 16'h0303, "R3 initial cfg", d, 16'h0303);
        wr(2'd0, 16'h0A00);
        rd(2'd0, d);
        check(d[0] == 1'b1, "R2 run sticky", d[0], 1);
        check(d == 16'h0303, "R3 cfg frozen", d, 16'h0303);
    endtask

    task automatic t_timeout();
        int t0, at;
        do_reset(1);
        wr(2'd0, 16'h0301); t0 = cyc;
        wait_req(60, at);
        check(at >= 0 && at - t0 >= 3*DIV - 1 && at - t0 <= 4*DIV + 2,
              "R4 expiry time", at - t0, 4*DIV);
        @(negedge clk);
        check(!rst_req, "R7 one cycle", rst_req, 0);
        check(ext_rst_n, "R8 no ext without select", ext_rst_n, 1);
    endtask

    task automatic t_service();
        int t0, at, base;
        do_reset(1);
        wr(2'd0, 16'h0301);
        base = req_cnt;
        for (int i = 0; i < 12; i++) begin
            wr(2'd1, 16'h5555);
            wr(2'd1, 16'hAAAA);
            repeat (10) @(negedge clk);
        end
        check(req_cnt == base, "R5 no expiry while serviced", req_cnt - base, 0);
        wr(2'd1, 16'h5555);
        wr(2'd1, 16'hAAAA); t0 = cyc;
        wait_req(60, at);
        check(at >= 0 && at - t0 >= 3*DIV - 1 && at - t0 <= 4*DIV + 4,
              "R5 expiry after last service", at - t0, 4*DIV);
    endtask

    task automatic t_bad_keys();
        int t0, at;
        do_reset(1);
        wr(2'd0, 16'h0301); t0 = cyc;
        repeat (12) @(negedge clk);
        wr(2'd1, 16'hAAAA);
        wr(2'd1, 16'h5555);
        wr(2'd1, 16'h1234);
        wr(2'd1, 16'hAAAA);
        wait_req(60, at);
        check(at >= 0 && at - t0 <= 4*DIV + 2, "R6 wrong order no reload",
              at - t0, 4*DIV);
    endtask

    task automatic t_ext_irq();
        logic [15:0] d;
        int n;
        do_reset(1);
        wr(2'd2, 16'h8000);
        wr(2'd0, 16'h0303);
        n = 0;
        while (ext_rst_n && n < 80) begin @(negedge clk); n++; end
        check(!ext_rst_n && rst_req, "R8 ext low with request",
              {ext_rst_n, rst_req}, 2'b01);
        check(irq, "R9 irq with ext reset", irq, 1);
        repeat (50) @(negedge clk);
        check(!ext_rst_n, "R8 ext held", ext_rst_n, 0);
        wr(2'd2, 16'hC000);
        rd(2'd2, d);
        check(!irq && d[14] == 1'b0, "R9 w1c clear", {irq, d[14]}, 0);
        do_reset(1);
        check(ext_rst_n, "R8 released by reset", ext_rst_n, 1);
    endtask

    task automatic t_pretimeout();
        int n, ti, at;
        do_reset(1);
        wr(2'd2, 16'h8002);
        wr(2'd0, 16'h0501);
        n = 0;
        while (!irq && !rst_req && n < 100) begin @(negedge clk); n++; end
        ti = cyc;
        check(irq && !rst_req, "R10 irq before request", {irq, rst_req}, 2'b10);
        wait_req(60, at);
        check(at - ti == 2*DIV, "R10 lead of P ticks", at - ti, 2*DIV);
    endtask

    task automatic t_powerdown();
        logic [15:0] d;
        int t0, at, base;
        do_reset(0); t0 = cyc;
        wait_req(60, at);
        check(at >= 0 && at - t0 >= (PD-1)*DIV && at - t0 <= PD*DIV + 3,
              "R11 pd expiry", at - t0, PD*DIV);
        wr(2'd3, 16'h0000);
        wr(2'd3, 16'h0001);
        rd(2'd3, d); check(d == 16'h0000, "R11 pd stays off", d, 0);
        base = req_cnt;
        repeat (100) @(negedge clk);
        check(req_cnt == base, "R11 no request once off", req_cnt - base, 0);
    endtask

    initial begin
        t_reset_state();
        t_lock();
        t_timeout();
        t_service();
        t_bad_keys();
        t_ext_irq();
        t_pretimeout();
        t_powerdown();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #150000;
        errors++; checks++;
        $display("FAIL watchdog: bench hung");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule